// File: doc/BRIEF.md
# SDRAM Write-Burst Interrupt Sequencer

This block is the command side of an SDRAM controller during a write burst of four beats issued without auto precharge. A host offers one request at a time: a Write, a Read, a single-bank Precharge or an all-bank Precharge, together with bank, column and a stream of write data. The block turns each accepted request into a registered command on the SDRAM command pins. It drives the write data with its output enable, and it drives the data mask.

A new request may cut a running write burst short, and each kind of interruption follows its own rule. A Write may take over on any cycle, and its data replaces the remaining old beats at once. A Read ends the burst on its own command cycle. It also keeps the data bus released until the read data has passed, so any later Write waits. A Precharge is held back until the write-recovery time has elapsed after the last real data beat. If it cut the burst short, the data mask covers every cycle from the one after that beat up to and including the Precharge.

When a request would break a spacing rule, `req_ready` stays low and the request waits; the host keeps it steady. The write-recovery count is fixed at elaboration time from the write-recovery time and the clock period, both in picoseconds. The read latency (2 or 3) is an input.

Top module: `wburst_seq`

## Requirements
- R1: After reset the command pins carry NOP, `dq_oe` and `dqm` are low, and a Write request is ready.
- R2: Command encodings on {cs_n, ras_n, cas_n, we_n}: NOP 0111, READ 0101, WRITE 0100, PRECHARGE 0010. Each request appears one cycle after the edge that accepts it. Read and Write put the column on the low address bits with address bit 10 low. A Precharge drives bit 10 high when `req_kind` is 3 (all banks) and low when it is 2 (one bank). Bank goes on `ba`.
- R3: A Write (`req_kind` 0) drives its first data beat in the WRITE command cycle, and then three more in consecutive cycles. Each beat is the `wr_data` value present in the cycle before, which `wr_take` marks. `dq_oe` is high exactly in beat cycles.
- R4: A Write is accepted on any cycle of a running burst. From its command cycle the old burst's remaining beats are dropped and four new beats follow.
- R5: A Read (`req_kind` 1) is always accepted. From the READ command cycle, no beat of the interrupted burst is driven or taken.
- R6: After a READ in cycle r, `dq_oe` stays low through cycle r+CL+3, where CL is 3 when `cas_lat3` is high and 2 otherwise. A Write request is not ready until its WRITE can appear in cycle r+CL+4.
- R7: A Precharge appears no earlier than cycle L+M, where L is the last cycle with `dq_oe` high and M = ceil(tWR/tCK) with a minimum of 1. It is accepted in the first cycle that allows this. A Precharge request that arrives during a burst cuts off the beats after the current one.
- R8: When a Precharge cuts off remaining beats, `dqm` is high from cycle L+1 through the PRECHARGE cycle and low otherwise.
- R9: A cycle without an accepted request carries NOP, and `dq_oe` is low whenever no beat is driven.
- R10: A stalled request is neither dropped nor repeated: each accepted request yields exactly one command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat3 | input | 1 | Read latency 3 when high, 2 when low |
| req_valid | input | 1 | Host request present |
| req_kind | input | 2 | 0 write, 1 read, 2 precharge one bank, 3 precharge all |
| req_bank | input | BA_W | Bank of the request |
| req_col | input | COL_W | Column of a read or write |
| req_ready | output | 1 | Request may be accepted this cycle |
| wr_data | input | DQ_W | Write data for the next beat |
| wr_take | output | 1 | `wr_data` is consumed at this edge |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| dq_oe | output | 1 | Data bus output enable |
| dq_out | output | DQ_W | Data driven to the bus |
| dqm | output | DQ_W/8 | Data mask, one bit per byte |

## Verification
A wrong beat counter shows up within one cycle as a beat too many or too few on `dq_oe`, or as a `wr_take` that does not match the next cycle's beat. A wrong recovery age shows up as a PRECHARGE that is one or more cycles off its cycle L+M, and a truncation flag that does not clear leaves `dqm` high past the PRECHARGE. A read-turnaround counter that is loaded or counted wrongly moves the WRITE that follows a READ off cycle r+CL+4. These faults are caught within one scenario of about twenty cycles.

// File: rtl/wburst_seq.sv
module wburst_seq #(
  parameter int DQ_W    = 16,
  parameter int BA_W    = 2,
  parameter int COL_W   = 8,
  parameter int ADDR_W  = 12,
  parameter int T_WR_PS = 15000,
  parameter int T_CK_PS = 7500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cas_lat3,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ready,
  input  logic [DQ_W-1:0]   wr_data,
  output logic              wr_take,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              dq_oe,
  output logic [DQ_W-1:0]   dq_out,
  output logic [DQ_W/8-1:0] dqm
);
  localparam int WR_RAW = (T_WR_PS + T_CK_PS - 1) / T_CK_PS;
  localparam int WR_CYC = (WR_RAW < 1) ? 1 : WR_RAW;
  localparam int AGE_W  = $clog2(WR_CYC + 1);
  localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(WR_CYC);
  localparam logic [AGE_W-1:0] AGE_PRE = AGE_W'(WR_CYC - 1);
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;

  logic [3:0]        cmd_q;
  logic [BA_W-1:0]   ba_q;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              oe_q, cut_q;
  logic [DQ_W-1:0]   dq_q;
  logic [1:0]        rem_q;
  logic [AGE_W-1:0]  age_q;
  logic [2:0]        rdc_q;

  wire is_wr  = (req_kind == 2'd0);
  wire is_rd  = (req_kind == 2'd1);
  wire is_pre = req_kind[1];
  wire pre_ok = (age_q >= AGE_PRE);

  assign req_ready = is_wr ? (rdc_q == 3'd0) : (is_pre ? pre_ok : 1'b1);

  wire fire    = req_valid & req_ready;
  wire fire_wr = fire & is_wr;
  wire fire_rd = fire & is_rd;
  wire halt    = req_valid & ~is_wr;
  wire more    = oe_q & (rem_q != 2'd0);
  wire cont    = more & ~halt;
  wire beat_n  = fire_wr | cont;
  wire cut_set = more & req_valid & is_pre;

  assign wr_take = beat_n;

  always_comb begin
    addr_n = '0;
    if (fire) begin
      if (is_pre) addr_n[10] = req_kind[0];
      else        addr_n[COL_W-1:0] = req_col;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= C_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      oe_q   <= 1'b0;
      dq_q   <= '0;
      rem_q  <= 2'd0;
      age_q  <= AGE_TOP;
      rdc_q  <= 3'd0;
      cut_q  <= 1'b0;
    end else begin
      cmd_q  <= fire ? (is_wr ? C_WR : (is_rd ? C_RD : C_PRE)) : C_NOP;
      if (fire) ba_q <= req_bank;
      addr_q <= addr_n;
      oe_q   <= beat_n;
      dq_q   <= beat_n ? wr_data : '0;
      rem_q  <= fire_wr ? 2'd3 : (cont ? rem_q - 2'd1 : 2'd0);
      if (beat_n)                age_q <= '0;
      else if (age_q != AGE_TOP) age_q <= age_q + 1'b1;
      if (fire_rd)               rdc_q <= cas_lat3 ? 3'd6 : 3'd5;
      else if (rdc_q != 3'd0)    rdc_q <= rdc_q - 3'd1;
      if (cut_set)               cut_q <= 1'b1;
      else if (cmd_q == C_PRE)   cut_q <= 1'b0;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba     = ba_q;
  assign addr   = addr_q;
  assign dq_oe  = oe_q;
  assign dq_out = dq_q;
  assign dqm    = {(DQ_W/8){cut_q}};
endmodule

// File: rtl/wburst_seq_chk.sv
module wburst_seq_chk #(
  parameter int T_WR_PS = 15000,
  parameter int T_CK_PS = 7500
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cmd,
  input logic       dq_oe,
  input logic       dqm_any,
  input logic       wr_take,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_kind
);
  localparam int WR_RAW = (T_WR_PS + T_CK_PS - 1) / T_CK_PS;
  localparam int WR_CYC = (WR_RAW < 1) ? 1 : WR_RAW;
  localparam logic [3:0] K_RD  = 4'b0101;
  localparam logic [3:0] K_WR  = 4'b0100;
  localparam logic [3:0] K_PRE = 4'b0010;
  localparam logic [3:0] K_NOP = 4'b0111;

  int gap;
  always_ff @(posedge clk) begin
    if (!rst_n)              gap <= WR_CYC;
    else if (dq_oe)          gap <= 1;
    else if (gap < WR_CYC)   gap <= gap + 1;
  end

  a_r3_take_drives: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> dq_oe);
  a_r5_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_RD) |-> !dq_oe);
  a_r6_read_next_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_RD) |=> !dq_oe);
  a_r7_pre_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_PRE) |-> (gap >= WR_CYC));
  a_r8_dqm_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    dqm_any |-> !dq_oe);
  a_r8_dqm_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (dqm_any && cmd == K_PRE) |=> !dqm_any);
  a_r9_oe_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (cmd == K_WR || cmd == K_NOP));
  a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_kind)));
endmodule

bind wburst_seq wburst_seq_chk #(.T_WR_PS(T_WR_PS), .T_CK_PS(T_CK_PS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd({cs_n, ras_n, cas_n, we_n}),
  .dq_oe(dq_oe), .dqm_any(|dqm), .wr_take(wr_take),
  .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind));

// File: tb/wburst_seq_bench.sv
module wburst_seq_bench;
  localparam int DQ_W = 16, BA_W = 2, COL_W = 8, ADDR_W = 12;
  localparam int T_WR = 14000, T_CK = 5000;
  localparam int M  = 3;
  localparam int NS = 24;
  localparam logic [3:0] NOP = 4'b0111, RD = 4'b0101, WR = 4'b0100, PRE = 4'b0010;

  logic clk = 1'b0, rst_n = 1'b0, cas_lat3 = 1'b0, req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [BA_W-1:0] req_bank = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [DQ_W-1:0] wr_data = '0;
  logic req_ready, wr_take, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [BA_W-1:0] ba;
  logic [ADDR_W-1:0] addr;
  logic [DQ_W-1:0] dq_out;
  logic [1:0] dqm;

  wburst_seq #(.DQ_W(DQ_W), .BA_W(BA_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
               .T_WR_PS(T_WR), .T_CK_PS(T_CK)) u_wburst_seq (
    .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3), .req_valid(req_valid),
    .req_kind(req_kind), .req_bank(req_bank), .req_col(req_col),
    .req_ready(req_ready), .wr_data(wr_data), .wr_take(wr_take),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
    .addr(addr), .dq_oe(dq_oe), .dq_out(dq_out), .dqm(dqm));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [3:0] e_cmd [0:NS];
  logic e_oe [0:NS];
  logic e_dqm [0:NS];
  logic [ADDR_W-1:0] e_addr [0:NS];
  logic [BA_W-1:0] e_ba [0:NS];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [DQ_W-1:0] wdat(int sc, int s);
    return DQ_W'(sc * 97 + s * 31 + 16'h1200) ^ 16'hA5C3;
  endfunction

  function automatic logic [ADDR_W-1:0] cadr(logic [COL_W-1:0] c);
    return ADDR_W'(c);
  endfunction

  task automatic scen(input int kind, input int k, input logic cl3, input int sc);
    logic [COL_W-1:0] ca, cb, cc;
    logic [BA_W-1:0] bA, bB, bC;
    int cl, ph, last, p, w, ncmd, nreq;
    ca = COL_W'($urandom); cb = COL_W'($urandom); cc = COL_W'($urandom);
    bA = BA_W'($urandom); bB = BA_W'($urandom); bC = BA_W'($urandom);
    cl = cl3 ? 3 : 2;
    w = 0; p = 0;
    for (int s = 0; s <= NS; s++) begin
      e_cmd[s] = NOP; e_oe[s] = 1'b0; e_dqm[s] = 1'b0; e_addr[s] = '0; e_ba[s] = '0;
    end
    e_cmd[1] = WR; e_addr[1] = cadr(ca); e_ba[1] = bA;
    if (kind == 0) begin
      e_cmd[k+1] = WR; e_addr[k+1] = cadr(cb); e_ba[k+1] = bB;
      for (int s = 1; s <= k + 4; s++) e_oe[s] = 1'b1;
    end else if (kind == 1) begin
      e_cmd[k+1] = RD; e_addr[k+1] = cadr(cb); e_ba[k+1] = bB;
      for (int s = 1; s <= k; s++) e_oe[s] = 1'b1;
      w = k + 1 + cl + 4;
      e_cmd[w] = WR; e_addr[w] = cadr(cc); e_ba[w] = bC;
      for (int s = w; s <= w + 3; s++) e_oe[s] = 1'b1;
    end else begin
      last = (k < 4) ? k : 4;
      p = (k + 1 > last + M) ? k + 1 : last + M;
      for (int s = 1; s <= last; s++) e_oe[s] = 1'b1;
      e_cmd[p] = PRE; e_ba[p] = bB;
      e_addr[p] = (kind == 3) ? ADDR_W'(1 << 10) : '0;
      if (k < 4) for (int s = last + 1; s <= p; s++) e_dqm[s] = 1'b1;
    end
    cas_lat3 = cl3;
    ph = 0; ncmd = 0; nreq = 0;
    for (int s = 0; s < NS; s++) begin
      @(negedge clk);
      chk((e_cmd[s] == NOP) ? "R9 cmd" : "R2 cmd", {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, e_cmd[s]});
      if ({cs_n, ras_n, cas_n, we_n} != NOP) ncmd++;
      chk((kind == 0) ? "R4 oe" : (kind == 1) ? "R5 oe" : "R7 oe", {31'd0, dq_oe}, {31'd0, e_oe[s]});
      chk("R8 dqm", {30'd0, dqm}, {30'd0, {2{e_dqm[s]}}});
      if (e_oe[s]) chk("R3 data", {16'd0, dq_out}, {16'd0, wdat(sc, s - 1)});
      if (e_cmd[s] != NOP) begin
        chk("R2 addr", {20'd0, addr}, {20'd0, e_addr[s]});
        chk("R2 bank", {30'd0, ba}, {30'd0, e_ba[s]});
      end
      wr_data = wdat(sc, s);
      req_valid = 1'b0;
      if (ph == 0) begin
        req_valid = 1'b1; req_kind = 2'd0; req_col = ca; req_bank = bA;
      end else if (ph == 1 && s >= k) begin
        req_valid = 1'b1; req_kind = 2'(kind); req_col = cb; req_bank = bB;
      end else if (ph == 2) begin
        req_valid = 1'b1; req_kind = 2'd0; req_col = cc; req_bank = bC;
      end
      #1;
      chk("R3 take", {31'd0, wr_take}, {31'd0, e_oe[s+1]});
      if (req_valid && ph == 2) chk("R6 ready", {31'd0, req_ready}, {31'd0, (s + 1 == w)});
      if (req_valid && ph == 1 && kind >= 2) chk("R7 ready", {31'd0, req_ready}, {31'd0, (s + 1 == p)});
      if (req_valid && req_ready) begin
        nreq++;
        ph = (ph == 1 && kind != 1) ? 3 : ph + 1;
      end
    end
    req_valid = 1'b0;
    chk("R10 one command per request", ncmd, nreq);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int sc;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 reset cmd", {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, NOP});
    chk("R1 reset oe", {31'd0, dq_oe}, 32'd0);
    chk("R1 reset dqm", {30'd0, dqm}, 32'd0);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    sc = 0;
    for (int c = 0; c < 2; c++) begin
      scen(0, 1, c[0], sc++); scen(0, 4, c[0], sc++);
      scen(1, 1, c[0], sc++); scen(1, 4, c[0], sc++);
      scen(2, 1, c[0], sc++); scen(3, 2, c[0], sc++);
      scen(2, 4, c[0], sc++); scen(3, 6, c[0], sc++);
    end
    for (int i = 0; i < 40; i++) begin
      int kd, kk;
      kd = int'($urandom % 4);
      kk = (kd >= 2) ? 1 + int'($urandom % 6) : 1 + int'($urandom % 4);
      scen(kd, kk, 1'($urandom), sc++);
    end
    summary();
  end
endmodule